// File: doc/BRIEF.md
# Clock Source Mode Controller

This block sets the operating mode of an on-chip clock generator. It reads three kinds of control: a two-bit clock select field, a bit that chooses the internal or the external reference, and a low-power bit. A debug-active flag also feeds in. From these it registers one of six modes. Each mode fixes four things: which source drives the output clock, whether the frequency-locked loop runs, whether the debug-communication clock is offered, and which reference oscillator is kept enabled. The select field chooses between two kinds of mode. In the loop-engaged modes the output comes from the loop. In the bypass modes the output comes straight from a reference.

The output clock passes through a glitch-free switch with one channel for each source. A channel is turned off on a falling edge of its own clock. The new channel is turned on only after the old one is off and the request has crossed two synchronizing stages clocked by the new source. A status bit reports when the handover has finished. A sticky flag records any control combination that is not a valid mode; such a combination leaves the current mode unchanged. The loop itself, the oscillators and the reference divider are outside this block. The divider is assumed to bring the external reference into the 31.25 kHz to 39.0625 kHz window before the loop locks to it.

Top module: `csm_clock_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first valid change after it, the block is in mode code 0 (loop locked to the internal reference). In this state `src_sel`=0, `loop_en`=1, `dbg_clk_en`=1, `int_ref_en`=1, `ext_ref_en`=0, `illegal_cfg`=0 and `switch_done`=0.
- R2: With `clk_sel`=00, `ref_int`=1 selects mode 0 and `ref_int`=0 selects mode 1 (loop locked to the external reference). Both modes give `src_sel`=0 (loop), `loop_en`=1 and `dbg_clk_en`=1. Mode 0 enables only the internal reference and mode 1 only the external one. `low_pwr` has no effect in either mode.
- R3: `clk_sel`=01 with `ref_int`=1 selects mode 2 (internal bypass) when `dbg_active`=1 or `low_pwr`=0. Mode 2 gives `src_sel`=1 (internal reference), `loop_en`=1, `dbg_clk_en`=1 and `int_ref_en`=1.
- R4: `clk_sel`=01 with `ref_int`=1, `low_pwr`=1 and `dbg_active`=0 selects mode 3 (internal bypass, low power). Mode 3 gives `src_sel`=1, `loop_en`=0, `dbg_clk_en`=0 and `int_ref_en`=1.
- R5: `clk_sel`=10 with `ref_int`=0 selects mode 4 when `dbg_active`=1 or `low_pwr`=0, and mode 5 otherwise. Both give `src_sel`=2 (external reference) and `ext_ref_en`=1. Mode 4 keeps `loop_en` and `dbg_clk_en` at 1; mode 5 drives both to 0.
- R6: Any other combination (`clk_sel`=11, 01 with `ref_int`=0, or 10 with `ref_int`=1) keeps the previous mode and all its outputs. It also sets `illegal_cfg`, which stays high until reset.
- R7: The mode outputs take their new value on the first rising edge of `clk` after the inputs change.
- R8: `switch_done` reads 0 in the cycle after any rising edge at which `clk_sel`, `ref_int` or `low_pwr` differs from its value at the previous edge. A change of `dbg_active` alone does not clear it.
- R9: `switch_done` rises only once the channel of the selected source is the only channel enabled, as seen in the `clk` domain. If the new mode uses the same source as before and the handover was already complete, it rises one cycle after it was cleared.
- R10: At most one switch channel is enabled at any time. Once `switch_done` is high, `out_clk` follows the clock of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the mode register and status |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Clock select field |
| ref_int | input | 1 | 1 = internal reference, 0 = external reference |
| low_pwr | input | 1 | Low-power request for the bypass modes |
| dbg_active | input | 1 | Debug session active; overrides `low_pwr` |
| loop_clk | input | 1 | Clock from the frequency-locked loop |
| int_ref_clk | input | 1 | Internal reference clock |
| ext_ref_clk | input | 1 | External reference clock |
| mode | output | 3 | Current mode code 0 to 5 |
| src_sel | output | 2 | Selected output source: 0 loop, 1 internal, 2 external |
| loop_en | output | 1 | Enable for the loop |
| dbg_clk_en | output | 1 | Debug-communication clock available |
| int_ref_en | output | 1 | Internal reference enable |
| ext_ref_en | output | 1 | External reference enable |
| illegal_cfg | output | 1 | Sticky invalid-control flag |
| switch_done | output | 1 | Output source handover complete |
| out_clk | output | 1 | Glitch-free switched output clock |

## Verification
The assertions assume that all three source clocks toggle freely, including the loop clock while `loop_en` is 0. A channel can only turn off on an edge of its own clock, so the assertions rely on this. The single-channel property also assumes that the control inputs do not bounce between sources faster than a handover takes. For that reason the stimulus holds each configuration for forty control cycles, which is well past the slowest handover. The inputs change only just after a falling edge of `clk`. The three source clocks have edges offset from the control grid, so no sample of `out_clk` lands on a source edge.

// File: rtl/csm_pkg.sv
package csm_pkg;

   typedef enum logic [2:0] {
      CSM_LOOP_INT   = 3'd0,
      CSM_LOOP_EXT   = 3'd1,
      CSM_BYP_INT    = 3'd2,
      CSM_BYP_INT_LP = 3'd3,
      CSM_BYP_EXT    = 3'd4,
      CSM_BYP_EXT_LP = 3'd5
   } csm_mode_e;

   localparam int CSM_NSRC     = 3;
   localparam int CSM_SRC_W    = $clog2(CSM_NSRC);
   localparam logic [CSM_SRC_W-1:0] CSM_SRC_LOOP = CSM_SRC_W'(0);
   localparam logic [CSM_SRC_W-1:0] CSM_SRC_INT  = CSM_SRC_W'(1);
   localparam logic [CSM_SRC_W-1:0] CSM_SRC_EXT  = CSM_SRC_W'(2);

   typedef struct packed {
      logic [CSM_SRC_W-1:0] src;
      logic                 loop_on;
      logic                 dbg_on;
      logic                 int_on;
      logic                 ext_on;
   } csm_attr_t;

   function automatic csm_attr_t csm_attr(input csm_mode_e m);
      csm_attr_t a;
      a = '{src: CSM_SRC_LOOP, loop_on: 1'b1, dbg_on: 1'b1, int_on: 1'b1, ext_on: 1'b0};
      case (m)
         CSM_LOOP_INT:   a = '{src: CSM_SRC_LOOP, loop_on: 1'b1, dbg_on: 1'b1, int_on: 1'b1, ext_on: 1'b0};
         CSM_LOOP_EXT:   a = '{src: CSM_SRC_LOOP, loop_on: 1'b1, dbg_on: 1'b1, int_on: 1'b0, ext_on: 1'b1};
         CSM_BYP_INT:    a = '{src: CSM_SRC_INT,  loop_on: 1'b1, dbg_on: 1'b1, int_on: 1'b1, ext_on: 1'b0};
         CSM_BYP_INT_LP: a = '{src: CSM_SRC_INT,  loop_on: 1'b0, dbg_on: 1'b0, int_on: 1'b1, ext_on: 1'b0};
         CSM_BYP_EXT:    a = '{src: CSM_SRC_EXT,  loop_on: 1'b1, dbg_on: 1'b1, int_on: 1'b0, ext_on: 1'b1};
         CSM_BYP_EXT_LP: a = '{src: CSM_SRC_EXT,  loop_on: 1'b0, dbg_on: 1'b0, int_on: 1'b0, ext_on: 1'b1};
         default:        a = '{src: CSM_SRC_LOOP, loop_on: 1'b1, dbg_on: 1'b1, int_on: 1'b1, ext_on: 1'b0};
      endcase
      return a;
   endfunction

endpackage

// File: rtl/csm_mode_decode.sv
module csm_mode_decode
   import csm_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] clk_sel,
   input  logic             ref_int,
   input  logic             low_pwr,
   input  logic             dbg_active,
   output logic             legal,
   output csm_mode_e        mode_next
);

   if (SEL_W != 2) begin : g_bad_sel_w
      $error("csm_mode_decode: SEL_W must be 2");
   end

   logic lp_eff;
   assign lp_eff = low_pwr & ~dbg_active;

   always_comb begin
      legal     = 1'b1;
      mode_next = CSM_LOOP_INT;
      unique case (clk_sel)
         2'b00: mode_next = ref_int ? CSM_LOOP_INT : CSM_LOOP_EXT;
         2'b01: begin
            if (ref_int) mode_next = lp_eff ? CSM_BYP_INT_LP : CSM_BYP_INT;
            else         legal     = 1'b0;
         end
         2'b10: begin
            if (!ref_int) mode_next = lp_eff ? CSM_BYP_EXT_LP : CSM_BYP_EXT;
            else          legal     = 1'b0;
         end
         default: legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/csm_mode_reg.sv
module csm_mode_reg
   import csm_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic             ref_int,
   input  logic             low_pwr,
   input  logic             legal,
   input  csm_mode_e        mode_next,
   input  logic             ack_ok,
   output csm_mode_e        mode_q,
   output logic             illegal_q,
   output logic             done_q
);

   localparam int CFG_W = SEL_W + 2;
   localparam logic [CFG_W-1:0] RST_CFG = {{SEL_W{1'b0}}, 1'b1, 1'b0};

   logic [CFG_W-1:0] cfg_now, cfg_q;
   logic             cfg_chg;

   assign cfg_now = {clk_sel, ref_int, low_pwr};
   assign cfg_chg = (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= CSM_LOOP_INT;
         illegal_q <= 1'b0;
         done_q    <= 1'b0;
         cfg_q     <= RST_CFG;
      end else begin
         cfg_q <= cfg_now;
         if (legal) mode_q    <= mode_next;
         else       illegal_q <= 1'b1;
         if (cfg_chg)     done_q <= 1'b0;
         else if (ack_ok) done_q <= 1'b1;
      end
   end

   assert_hold_on_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !legal |=> $stable(mode_q));
   assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_q |=> illegal_q);
   assert_done_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> !done_q);
   assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(ack_ok));

endmodule

// File: rtl/csm_clk_switch.sv
module csm_clk_switch #(
   parameter int NSRC        = 3,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             ctl_clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_clk,
   input  logic [SEL_W-1:0] sel_idx,
   output logic [NSRC-1:0]  ack_vec,
   output logic             out_clk
);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("csm_clk_switch: NSRC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("csm_clk_switch: SYNC_STAGES must be at least 2");
   end

   logic [NSRC-1:0] en_vec;
   logic [NSRC-1:0] gated;

   for (genvar i = 0; i < NSRC; i++) begin : g_ch
      logic [NSRC-1:0]        others;
      logic                   req;
      logic [SYNC_STAGES-1:0] req_sync;
      logic                   en;
      logic [SYNC_STAGES-1:0] ack_sync;

      assign others = en_vec & ~(NSRC'(1) << i);
      assign req    = (sel_idx == SEL_W'(i)) && (others == '0);

      always_ff @(posedge src_clk[i] or negedge rst_n) begin
         if (!rst_n) req_sync <= '0;
         else        req_sync <= {req_sync[SYNC_STAGES-2:0], req};
      end

      always_ff @(negedge src_clk[i] or negedge rst_n) begin
         if (!rst_n) en <= 1'b0;
         else        en <= req_sync[SYNC_STAGES-1];
      end

      always_ff @(posedge ctl_clk or negedge rst_n) begin
         if (!rst_n) ack_sync <= '0;
         else        ack_sync <= {ack_sync[SYNC_STAGES-2:0], en};
      end

      assign en_vec[i]  = en;
      assign gated[i]   = src_clk[i] & en;
      assign ack_vec[i] = ack_sync[SYNC_STAGES-1];
   end

   assign out_clk = |gated;

   assert_single_channel_R10: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $onehot0(en_vec));
   assert_single_ack_R10: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $onehot0(ack_vec));

endmodule

// File: rtl/csm_clock_mode_ctrl.sv
module csm_clock_mode_ctrl
   import csm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] clk_sel,
   input  logic       ref_int,
   input  logic       low_pwr,
   input  logic       dbg_active,
   input  logic       loop_clk,
   input  logic       int_ref_clk,
   input  logic       ext_ref_clk,
   output logic [2:0] mode,
   output logic [1:0] src_sel,
   output logic       loop_en,
   output logic       dbg_clk_en,
   output logic       int_ref_en,
   output logic       ext_ref_en,
   output logic       illegal_cfg,
   output logic       switch_done,
   output logic       out_clk
);

   localparam int SEL_W = 2;

   if (CSM_SRC_W != 2) begin : g_bad_src_w
      $error("csm_clock_mode_ctrl: source index must be 2 bits wide");
   end

   logic            legal;
   csm_mode_e       mode_next;
   csm_mode_e       mode_q;
   csm_attr_t       attr;
   logic [CSM_NSRC-1:0] ack_vec;
   logic            ack_ok;

   csm_mode_decode #(.SEL_W(SEL_W)) u_decode (
      .clk_sel    (clk_sel),
      .ref_int    (ref_int),
      .low_pwr    (low_pwr),
      .dbg_active (dbg_active),
      .legal      (legal),
      .mode_next  (mode_next)
   );

   csm_mode_reg #(.SEL_W(SEL_W)) u_mode_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_sel   (clk_sel),
      .ref_int   (ref_int),
      .low_pwr   (low_pwr),
      .legal     (legal),
      .mode_next (mode_next),
      .ack_ok    (ack_ok),
      .mode_q    (mode_q),
      .illegal_q (illegal_cfg),
      .done_q    (switch_done)
   );

   assign attr   = csm_attr(mode_q);
   assign ack_ok = (ack_vec == (CSM_NSRC'(1) << attr.src));

   csm_clk_switch #(.NSRC(CSM_NSRC), .SYNC_STAGES(SYNC_STAGES)) u_switch (
      .ctl_clk (clk),
      .rst_n   (rst_n),
      .src_clk ({ext_ref_clk, int_ref_clk, loop_clk}),
      .sel_idx (attr.src),
      .ack_vec (ack_vec),
      .out_clk (out_clk)
   );

   assign mode       = mode_q;
   assign src_sel    = attr.src;
   assign loop_en    = attr.loop_on;
   assign dbg_clk_en = attr.dbg_on;
   assign int_ref_en = attr.int_on;
   assign ext_ref_en = attr.ext_on;

   assert_dbg_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_active && clk_sel == 2'b01 && ref_int) |=> (mode == 3'd2));
   assert_lp_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_active && low_pwr && clk_sel == 2'b01 && ref_int) |=> (!loop_en && !dbg_clk_en));
   assert_one_reference_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({int_ref_en, ext_ref_en}) == 1);
   assert_lp_ignored_in_loop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 2'b00) |=> (loop_en && dbg_clk_en && src_sel == 2'd0));

endmodule

// File: tb/csm_clock_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module csm_clock_mode_ctrl_tb_top;

   localparam real CLK_HALF = 5.0;
   localparam int  PEND_MAX = 60;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] clk_sel = 2'b00;
   logic ref_int = 1'b1, low_pwr = 1'b0, dbg_active = 1'b0;
   logic loop_clk = 1'b0, int_ref_clk = 1'b0, ext_ref_clk = 1'b0;
   logic [2:0] mode;
   logic [1:0] src_sel;
   logic loop_en, dbg_clk_en, int_ref_en, ext_ref_en, illegal_cfg, switch_done, out_clk;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   csm_clock_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ref_int(ref_int),
      .low_pwr(low_pwr), .dbg_active(dbg_active), .loop_clk(loop_clk),
      .int_ref_clk(int_ref_clk), .ext_ref_clk(ext_ref_clk), .mode(mode),
      .src_sel(src_sel), .loop_en(loop_en), .dbg_clk_en(dbg_clk_en),
      .int_ref_en(int_ref_en), .ext_ref_en(ext_ref_en), .illegal_cfg(illegal_cfg),
      .switch_done(switch_done), .out_clk(out_clk)
   );

   always #(CLK_HALF) clk = ~clk;
   initial begin #0.25; forever #3  loop_clk    = ~loop_clk;    end
   initial begin #0.25; forever #7  int_ref_clk = ~int_ref_clk; end
   initial begin #0.25; forever #11 ext_ref_clk = ~ext_ref_clk; end

   // reference model state
   int m_mode = 0, m_ill = 0, m_prev_cfg = 4'b0010;
   int d_state = 0, d_next = 2, pend = 0;   // 0: expect low, 1: expect high, 2: pending

   function automatic int src_of(input int m);
      if (m <= 1) return 0;
      if (m <= 3) return 1;
      return 2;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_ill = 0; m_prev_cfg = 4'b0010; d_state = 0; d_next = 2; pend = 0;
      end else begin
         int cfg, nm, old_src, was_done;
         bit ok;
         cfg = {clk_sel, ref_int, low_pwr};
         ok = 1; nm = m_mode;
         if (clk_sel == 2'b00) nm = ref_int ? 0 : 1;
         else if (clk_sel == 2'b01 && ref_int)  nm = (low_pwr && !dbg_active) ? 3 : 2;
         else if (clk_sel == 2'b10 && !ref_int) nm = (low_pwr && !dbg_active) ? 5 : 4;
         else ok = 0;
         old_src = src_of(m_mode);
         was_done = (d_state == 1);
         if (ok) m_mode = nm; else m_ill = 1;
         if (cfg != m_prev_cfg) begin
            d_next = (was_done && src_of(m_mode) == old_src) ? 1 : 2;
            d_state = 0;
         end else if (d_state == 0) begin
            d_state = d_next;
            pend = 0;
         end
         m_prev_cfg = cfg;
      end
   end

   always @(negedge clk) begin
      string rq;
      int sclk;
      rq = !rst_n ? "R1" : (m_mode <= 1) ? "R2" : (m_mode == 2) ? "R3" :
           (m_mode == 3) ? "R4" : "R5";
      chk(rq, "mode R7", mode, m_mode);
      chk(rq, "src_sel", src_sel, src_of(m_mode));
      chk(rq, "loop_en", loop_en, (m_mode != 3 && m_mode != 5));
      chk(rq, "dbg_clk_en", dbg_clk_en, (m_mode != 3 && m_mode != 5));
      chk(rq, "int_ref_en", int_ref_en, (m_mode == 0 || m_mode == 2 || m_mode == 3));
      chk(rq, "ext_ref_en", ext_ref_en, (m_mode == 1 || m_mode == 4 || m_mode == 5));
      chk(rst_n ? "R6" : "R1", "illegal_cfg", illegal_cfg, m_ill);
      if (!rst_n || d_state == 0) chk(rst_n ? "R8" : "R1", "switch_done low", switch_done, 0);
      else if (d_state == 1) begin
         chk("R9", "switch_done high", switch_done, 1);
         sclk = (src_of(m_mode) == 0) ? loop_clk : (src_of(m_mode) == 1) ? int_ref_clk : ext_ref_clk;
         chk("R10", "out_clk follows source", out_clk, sclk);
      end else begin
         if (switch_done) d_state = 1;
         else begin
            pend++;
            if (pend > PEND_MAX) begin
               chk("R9", "switch_done timeout", switch_done, 1);
               d_state = 1;
            end
         end
      end
   end

   task automatic apply(input logic [1:0] s, input logic r, input logic lp, input logic d);
      @(negedge clk); #1;
      clk_sel = s; ref_int = r; low_pwr = lp; dbg_active = d;
      repeat (40) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (40) @(negedge clk);
      apply(2'b00, 1'b0, 1'b0, 1'b0);   // R2 external loop, same source
      apply(2'b00, 1'b0, 1'b1, 1'b0);   // R2 low_pwr ignored, R8 clear
      apply(2'b01, 1'b1, 1'b0, 1'b0);   // R3
      apply(2'b01, 1'b1, 1'b1, 1'b0);   // R4
      apply(2'b01, 1'b1, 1'b1, 1'b1);   // R3 debug override, R8 no clear
      apply(2'b01, 1'b1, 1'b1, 1'b0);   // R4 again
      apply(2'b10, 1'b0, 1'b1, 1'b1);   // R5 mode 4 via debug
      apply(2'b10, 1'b0, 1'b1, 1'b0);   // R5 mode 5
      apply(2'b10, 1'b0, 1'b0, 1'b0);   // R5 mode 4
      apply(2'b11, 1'b0, 1'b0, 1'b0);   // R6
      apply(2'b01, 1'b0, 1'b0, 1'b0);   // R6
      apply(2'b10, 1'b1, 1'b0, 1'b0);   // R6
      apply(2'b00, 1'b1, 1'b0, 1'b0);   // R2 back to loop, flag stays
      @(negedge clk); #1 rst_n = 1'b0;  // R1 second reset clears flag
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (40) @(negedge clk);
      apply(2'b01, 1'b1, 1'b0, 1'b0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule